// File: doc/BRIEF.md
# Multicycle Load/Store Instruction Sequencer

This block is a small processor core that executes one instruction at a time through a fetch phase and an execute phase. It keeps a program counter and reads 32-bit instruction words through a single synchronous, byte-addressed memory port. Each word is latched into an instruction register and then decoded. The core supports word loads and stores with a register-plus-offset address, register and immediate addition and subtraction, and two conditional branches: one tests a single register against zero, the other compares two registers. A halt instruction stops the core.

Memory is reached only through load and store. Arithmetic takes its operands from registers or from a sign-extended 16-bit field of the instruction word. The general registers are not cleared by reset, so a program must load or compute a value before it reads it. The memory port answers one cycle after a strobe: the address is driven in one cycle and the read data is taken at the following clock edge. The core is intended as a compact, easily checked sequencer for small control programs such as summing a list held in memory.

Top module: `ldst_core`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `halt` and `mem_wr` are 0. That first cycle is a fetch: `mem_rd`=1 and `mem_addr`=RESET_PC.
- R2: Each instruction starts with one cycle that has `mem_rd`=1 and `mem_addr`=PC. The next cycle has no strobe, and in it the word on `mem_rdata` becomes the instruction. Fields: opcode [31:26], ra [25:21], rb [20:16], rc [15:11], imm [15:0] (signed).
- R3: Every instruction that is not a taken branch advances the PC by 4. After four straight-line instructions starting at address A, the next fetch is at A+16.
- R4: Load (opcode 0x01) reads the word at R[rb]+imm with a read strobe in its fourth cycle and writes it into R[ra] one cycle later. A load takes 5 cycles.
- R5: Store (opcode 0x02) writes R[ra] to R[rb]+imm with a write strobe in its fourth cycle and takes 4 cycles. No other instruction drives `mem_wr`, and `mem_rd` and `mem_wr` are never high in the same cycle.
- R6: Add (0x03) and Subtract (0x04) set R[ra] to R[rb] plus or minus R[rc]. Add-immediate (0x05) and Subtract-immediate (0x06) use the sign-extended imm in place of R[rc]. Results wrap modulo 2^32, and each of these instructions takes 4 cycles.
- R7: Branch-if-positive (0x07) jumps to PC+4+(imm<<2) when R[ra], read as a signed value, is greater than zero. Otherwise it goes on to PC+4. It takes 3 cycles.
- R8: Branch-if-greater (0x08) jumps to PC+4+(imm<<2) when R[ra] is greater than R[rb] as signed values. Otherwise it goes on to PC+4. It takes 3 cycles.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Halt (0x3F) takes 3 cycles. After it, `halt` stays 1 and no memory strobe is driven until reset.
- R11: Any other opcode does nothing except advance the PC by 4, and takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | W | Byte address of the current memory access |
| mem_wdata | output | W | Data for a store |
| mem_rdata | input | W | Data returned one cycle after a read strobe |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |
| halt | output | 1 | High once a halt instruction has executed |

## Verification
Three programs are run, each against a behavioural instruction-level model that predicts the bus activity in every cycle.

- **Straight-line program.** It loads two words, adds them and stores the sum. This separates correct PC stepping and load timing from off-by-one fetch addresses. A negative operand exposes a missing sign treatment.
- **List-summing loop.** It uses indexed loads, an immediate decrement and a branch back to the loop start. This shows whether negative branch offsets and the branch decision work across repeated passes.
- **Mixed program.** It pairs signed operands in both compare orders, so a design that compares unsigned, or swaps the operands, takes the wrong path. It also tries to write register 0, runs an unassigned opcode and branches on zero and negative values, so a core that acts on these cases leaves a different memory image or a different fetch trace.

// File: rtl/ldst_pkg.sv
// Package: shared encodings and types of the load/store sequencer.
// Assumes a fixed 32-bit instruction word with the field layout below.
package ldst_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 6;
    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h01;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h02;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'h03;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h05;
    localparam logic [OPC_W-1:0] OPC_SUBI  = 6'h06;
    localparam logic [OPC_W-1:0] OPC_BGTZ  = 6'h07;
    localparam logic [OPC_W-1:0] OPC_BGT   = 6'h08;
    localparam logic [OPC_W-1:0] OPC_HALT  = 6'h3F;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB,
        ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_ALU,
        K_BRZ,
        K_BR2,
        K_HALT,
        K_NOP
    } insn_kind_e;

    typedef enum logic {
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    typedef struct packed {
        insn_kind_e              kind;
        alu_op_e                 op;
        logic                    use_imm;
        logic [RIDX_W-1:0]       ra;
        logic [RIDX_W-1:0]       rb;
        logic [RIDX_W-1:0]       rc;
        logic [IMM_W-1:0]        imm;
    } insn_t;

endpackage

// File: rtl/ldst_decode.sv
// Module: ldst_decode
// Purely combinational decoder from the instruction register to a control
// record. Assumes the word is stable for the whole execute phase.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [INSN_W-1:0] ir,
    output insn_t             insn
);

    logic [OPC_W-1:0] opc;

    assign opc = ir[31:26];

    // Split fields and classify the opcode.
    always_comb begin
        insn.kind    = K_NOP;
        insn.op      = ALU_ADD;
        insn.use_imm = 1'b0;
        insn.ra      = ir[25:21];
        insn.rb      = ir[20:16];
        insn.rc      = ir[15:11];
        insn.imm     = ir[15:0];
        case (opc)
            OPC_LOAD:  insn.kind = K_LOAD;
            OPC_STORE: insn.kind = K_STORE;
            OPC_ADD: begin
                insn.kind = K_ALU;
            end
            OPC_SUB: begin
                insn.kind = K_ALU;
                insn.op   = ALU_SUB;
            end
            OPC_ADDI: begin
                insn.kind    = K_ALU;
                insn.use_imm = 1'b1;
            end
            OPC_SUBI: begin
                insn.kind    = K_ALU;
                insn.op      = ALU_SUB;
                insn.use_imm = 1'b1;
            end
            OPC_BGTZ:  insn.kind = K_BRZ;
            OPC_BGT:   insn.kind = K_BR2;
            OPC_HALT:  insn.kind = K_HALT;
            default:   insn.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/ldst_regfile.sv
// Module: ldst_regfile
// General register array with NRD combinational read ports and one write
// port. Entry 0 reads as zero and ignores writes. Contents are not reset.
module ldst_regfile
    import ldst_pkg::*;
#(
    parameter int W   = 32,
    parameter int NRD = 3
) (
    input  logic              clk,
    input  logic [RIDX_W-1:0] raddr [NRD],
    output logic [W-1:0]      rdata [NRD],
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [W-1:0]      wdata
);

    logic [W-1:0] regs [NREG];

    // Write port; register 0 is never written.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports, one per generated lane.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

endmodule

// File: rtl/ldst_alu.sv
// Module: ldst_alu
// Adder/subtractor with a signed greater-than flag used by branches.
// Assumes two's complement operands of width W.
module ldst_alu
    import ldst_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         gt
);

    // Sum or difference, wrapping at W bits.
    always_comb begin
        if (op == ALU_SUB) begin
            y = a - b;
        end else begin
            y = a + b;
        end
    end

    // Signed comparison for the conditional branches.
    assign gt = $signed(a) > $signed(b);

endmodule

// File: rtl/ldst_ctrl.sv
// Module: ldst_ctrl
// Sequencing state machine with program counter, instruction register and
// execute-phase result registers. Assumes the memory returns read data one
// cycle after a read strobe.
module ldst_ctrl
    import ldst_pkg::*;
#(
    parameter int           W        = 32,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  insn_kind_e        kind,
    input  alu_op_e           op,
    input  logic              use_imm,
    input  logic [RIDX_W-1:0] ra,
    input  logic [IMM_W-1:0]  imm,
    output logic [INSN_W-1:0] ir_q,
    input  logic [W-1:0]      rd_a,
    input  logic [W-1:0]      rd_b,
    input  logic [W-1:0]      rd_c,
    output logic [W-1:0]      alu_a,
    output logic [W-1:0]      alu_b,
    output alu_op_e           alu_op,
    input  logic [W-1:0]      alu_y,
    input  logic              alu_gt,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [W-1:0]      rf_wdata,
    output logic              halt,
    output logic              in_fetch
);

    localparam logic [W-1:0] PC_STEP = W'(4);

    seq_state_e   state;
    logic [W-1:0] pc;
    logic [W-1:0] res_q;
    logic [W-1:0] sdata_q;
    logic [W-1:0] imm_sx;
    logic [W-1:0] br_off;

    assign imm_sx = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
    assign br_off = {imm_sx[W-3:0], 2'b00};

    // State, PC, instruction and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            pc      <= RESET_PC;
            ir_q    <= '0;
            res_q   <= '0;
            sdata_q <= '0;
        end else begin
            case (state)
                ST_FETCH: begin
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    ir_q  <= mem_rdata[INSN_W-1:0];
                    pc    <= pc + PC_STEP;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    res_q   <= alu_y;
                    sdata_q <= rd_a;
                    case (kind)
                        K_LOAD, K_STORE: state <= ST_MEM;
                        K_ALU:           state <= ST_WB;
                        K_BRZ, K_BR2: begin
                            if (alu_gt) begin
                                pc <= pc + br_off;
                            end
                            state <= ST_FETCH;
                        end
                        K_HALT:          state <= ST_HALT;
                        default:         state <= ST_FETCH;
                    endcase
                end
                ST_MEM: begin
                    state <= (kind == K_LOAD) ? ST_WB : ST_FETCH;
                end
                ST_WB: begin
                    state <= ST_FETCH;
                end
                default: begin
                    state <= ST_HALT;
                end
            endcase
        end
    end

    // Operand selection for the ALU by instruction class.
    always_comb begin
        alu_a  = rd_b;
        alu_b  = imm_sx;
        alu_op = ALU_ADD;
        case (kind)
            K_ALU: begin
                alu_a  = rd_b;
                alu_b  = use_imm ? imm_sx : rd_c;
                alu_op = op;
            end
            K_BRZ: begin
                alu_a = rd_a;
                alu_b = '0;
            end
            K_BR2: begin
                alu_a = rd_a;
                alu_b = rd_b;
            end
            default: begin
                alu_a = rd_b;
                alu_b = imm_sx;
            end
        endcase
    end

    // Memory port drive for fetch, load and store.
    always_comb begin
        mem_rd    = (state == ST_FETCH) || ((state == ST_MEM) && (kind == K_LOAD));
        mem_wr    = (state == ST_MEM) && (kind == K_STORE);
        mem_addr  = (state == ST_FETCH) ? pc : res_q;
        mem_wdata = sdata_q;
    end

    // Register write-back from load data or the ALU result.
    always_comb begin
        rf_we    = (state == ST_WB);
        rf_waddr = ra;
        rf_wdata = (kind == K_LOAD) ? mem_rdata : res_q;
    end

    assign halt     = (state == ST_HALT);
    assign in_fetch = (state == ST_FETCH);

endmodule

// File: rtl/ldst_core.sv
// Module: ldst_core (top)
// Multicycle load/store sequencer: fetch, decode, execute, memory access and
// write-back over one synchronous memory port. Assumes W >= 32 and a memory
// that answers a read strobe with data one cycle later.
module ldst_core
    import ldst_pkg::*;
#(
    parameter int           W        = 32,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         halt
);

    localparam int NRD = 3;

    logic [INSN_W-1:0] ir_q;
    insn_t             insn;
    logic [RIDX_W-1:0] rf_raddr [NRD];
    logic [W-1:0]      rf_rdata [NRD];
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [W-1:0]      rf_wdata;
    logic [W-1:0]      alu_a;
    logic [W-1:0]      alu_b;
    alu_op_e           alu_op;
    logic [W-1:0]      alu_y;
    logic              alu_gt;
    logic              in_fetch;

    assign rf_raddr[0] = insn.ra;
    assign rf_raddr[1] = insn.rb;
    assign rf_raddr[2] = insn.rc;

    ldst_decode u_dec (
        .ir   (ir_q),
        .insn (insn)
    );

    ldst_regfile #(.W(W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    ldst_alu #(.W(W)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .op (alu_op),
        .y  (alu_y),
        .gt (alu_gt)
    );

    ldst_ctrl #(.W(W), .RESET_PC(RESET_PC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (insn.kind),
        .op        (insn.op),
        .use_imm   (insn.use_imm),
        .ra        (insn.ra),
        .imm       (insn.imm),
        .ir_q      (ir_q),
        .rd_a      (rf_rdata[0]),
        .rd_b      (rf_rdata[1]),
        .rd_c      (rf_rdata[2]),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_op    (alu_op),
        .alu_y     (alu_y),
        .alu_gt    (alu_gt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .halt      (halt),
        .in_fetch  (in_fetch)
    );

endmodule

// File: rtl/ldst_core_chk.sv
// Module: ldst_core_chk
// Property checker bound to ldst_core. Watches the memory port, the halt
// flag and the fetch indication across clock cycles.
module ldst_core_chk #(
    parameter int           W        = 32,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mem_addr,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic         halt,
    input logic         in_fetch
);

    // R1: first cycle out of reset is a fetch at the reset address.
    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_rd && (mem_addr == RESET_PC) && !halt && !mem_wr));

    // R2: fetch addresses are word aligned.
    assert_fetch_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |-> (mem_addr[1:0] == 2'b00));

    // R2: the cycle after a fetch has no strobe.
    assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |=> (!mem_rd && !mem_wr));

    // R5: never a read and a write together.
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5: a write follows a cycle without any strobe.
    assert_store_after_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(!mem_rd) && $past(!mem_wr)));

    // R10: halted core is silent on the bus.
    assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!mem_rd && !mem_wr));

    // R10: halt holds until reset.
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

endmodule

bind ldst_core ldst_core_chk #(.W(W), .RESET_PC(RESET_PC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halt     (halt),
    .in_fetch (in_fetch)
);

// File: tb/ldst_core_tb_top.sv
`timescale 1ns/1ps
// Bench: runs three programs against a behavioural instruction model that
// predicts the bus activity of every cycle, then checks memory results.
module ldst_core_tb_top;

    localparam int W  = 32;
    localparam int MW = 256;

    localparam logic [5:0] T_LOAD  = 6'h01;
    localparam logic [5:0] T_STORE = 6'h02;
    localparam logic [5:0] T_ADD   = 6'h03;
    localparam logic [5:0] T_SUB   = 6'h04;
    localparam logic [5:0] T_ADDI  = 6'h05;
    localparam logic [5:0] T_SUBI  = 6'h06;
    localparam logic [5:0] T_BGTZ  = 6'h07;
    localparam logic [5:0] T_BGT   = 6'h08;
    localparam logic [5:0] T_HALT  = 6'h3F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_wdata;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_rd;
    logic         mem_wr;
    logic         halt;

    always #2.5 clk = ~clk;

    ldst_core #(.W(W), .RESET_PC('0)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halt      (halt)
    );

    // Bench memory seen by the design.
    logic [W-1:0] dmem [MW];
    always @(posedge clk) begin
        if (mem_wr) dmem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= dmem[mem_addr[9:2]];
    end

    typedef struct {
        logic        rd;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        hlt;
        string       tag;
    } cyc_t;

    cyc_t        expq[$];
    logic [31:0] mr [32];
    logic [31:0] mmem [MW];
    logic [31:0] mpc;
    bit          mhalted;
    string       ftag;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] ra,
                                          input logic [4:0] rb, input logic [15:0] imm);
        return {op, ra, rb, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [4:0] ra,
                                          input logic [4:0] rb, input logic [4:0] rc);
        return {op, ra, rb, rc, 11'b0};
    endfunction

    task automatic put(input logic [31:0] addr, input logic [31:0] val);
        dmem[addr[9:2]] = val;
        mmem[addr[9:2]] = val;
    endtask

    task automatic push(input logic rd, input logic wr, input logic [31:0] addr,
                        input logic [31:0] wd, input logic hlt, input string tag);
        cyc_t e;
        e.rd = rd; e.wr = wr; e.addr = addr; e.wdata = wd; e.hlt = hlt; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic setr(input logic [4:0] idx, input logic [31:0] val);
        if (idx != 0) mr[idx] = val;
    endtask

    // Instruction-level model: executes one instruction, queues its cycles.
    task automatic model_step();
        logic [31:0] ir, sx, ea, nxt;
        logic [4:0]  ra, rb, rc;
        if (mhalted) begin
            push(0, 0, 0, 0, 1, "R10");
            return;
        end
        ir = mmem[mpc[9:2]];
        ra = ir[25:21]; rb = ir[20:16]; rc = ir[15:11];
        sx = {{16{ir[15]}}, ir[15:0]};
        ea = mr[rb] + sx;
        nxt = mpc + 4;
        push(1, 0, mpc, 0, 0, ftag);
        push(0, 0, 0, 0, 0, "R2");
        ftag = "R3";
        case (ir[31:26])
            T_LOAD: begin
                push(0, 0, 0, 0, 0, "R4");
                push(1, 0, ea, 0, 0, "R4");
                push(0, 0, 0, 0, 0, "R4");
                setr(ra, mmem[ea[9:2]]);
            end
            T_STORE: begin
                push(0, 0, 0, 0, 0, "R5");
                push(0, 1, ea, mr[ra], 0, "R5");
                mmem[ea[9:2]] = mr[ra];
            end
            T_ADD, T_SUB, T_ADDI, T_SUBI: begin
                logic [31:0] opb;
                opb = (ir[31:26] == T_ADDI || ir[31:26] == T_SUBI) ? sx : mr[rc];
                push(0, 0, 0, 0, 0, "R6");
                push(0, 0, 0, 0, 0, "R6");
                if (ir[31:26] == T_ADD || ir[31:26] == T_ADDI) setr(ra, mr[rb] + opb);
                else setr(ra, mr[rb] - opb);
            end
            T_BGTZ: begin
                push(0, 0, 0, 0, 0, "R7");
                if ($signed(mr[ra]) > 0) nxt = nxt + {sx[29:0], 2'b00};
                ftag = "R7";
            end
            T_BGT: begin
                push(0, 0, 0, 0, 0, "R8");
                if ($signed(mr[ra]) > $signed(mr[rb])) nxt = nxt + {sx[29:0], 2'b00};
                ftag = "R8";
            end
            T_HALT: begin
                push(0, 0, 0, 0, 0, "R10");
                mhalted = 1;
            end
            default: begin
                push(0, 0, 0, 0, 0, "R11");
                ftag = "R11";
            end
        endcase
        mpc = nxt;
    endtask

    task automatic clear_mem();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < MW; i++) begin
            dmem[i] = '0;
            mmem[i] = '0;
        end
    endtask

    // Releases reset and compares the bus to the model every cycle.
    task automatic run_prog(input int maxcyc);
        int   hold;
        bit   fin;
        cyc_t e;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(halt == 1'b0, "R1", "halt in reset", {31'b0, halt}, 0);
        check(mem_wr == 1'b0, "R1", "write strobe in reset", {31'b0, mem_wr}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mr[i] = '0;
        mpc = 0; mhalted = 0; ftag = "R1"; expq.delete();
        hold = 0; fin = 0;
        for (int c = 0; c < maxcyc; c++) begin
            if (expq.size() == 0) model_step();
            e = expq.pop_front();
            check(mem_rd == e.rd, e.tag, "read strobe", {31'b0, mem_rd}, {31'b0, e.rd});
            check(mem_wr == e.wr, e.tag, "write strobe", {31'b0, mem_wr}, {31'b0, e.wr});
            check(halt == e.hlt, e.tag, "halt flag", {31'b0, halt}, {31'b0, e.hlt});
            if (e.rd || e.wr) check(mem_addr == e.addr, e.tag, "address", mem_addr, e.addr);
            if (e.wr) check(mem_wdata == e.wdata, e.tag, "store data", mem_wdata, e.wdata);
            if (e.hlt) hold++;
            if (hold > 3) begin
                fin = 1;
                break;
            end
            @(negedge clk);
        end
        if (!fin) check(0, "R10", "program did not halt", 0, 1);
    endtask

    initial begin
        // Program 1: straight line, sum of two words (R3, R4, R5, R6).
        clear_mem();
        put(32'h00, enc_i(T_LOAD, 2, 0, 16'h0100));
        put(32'h04, enc_i(T_LOAD, 3, 0, 16'h0104));
        put(32'h08, enc_r(T_ADD, 4, 2, 3));
        put(32'h0C, enc_i(T_STORE, 4, 0, 16'h0108));
        put(32'h10, {T_HALT, 26'b0});
        put(32'h100, 32'd7);
        put(32'h104, 32'hFFFF_FFF0);
        run_prog(200);
        check(dmem[32'h108 >> 2] == 32'hFFFF_FFF7, "R6", "sum stored", dmem[32'h108 >> 2], 32'hFFFF_FFF7);

        // Program 2: list-summing loop with backward branch (R4, R7).
        clear_mem();
        put(32'h00, enc_i(T_LOAD, 2, 0, 16'h0140));
        put(32'h04, enc_i(T_ADDI, 3, 0, 16'h0150));
        put(32'h08, enc_i(T_ADDI, 4, 0, 16'h0000));
        put(32'h0C, enc_i(T_LOAD, 5, 3, 16'h0000));
        put(32'h10, enc_r(T_ADD, 4, 4, 5));
        put(32'h14, enc_i(T_ADDI, 3, 3, 16'h0004));
        put(32'h18, enc_i(T_SUBI, 2, 2, 16'h0001));
        put(32'h1C, enc_i(T_BGTZ, 2, 0, 16'hFFFB));
        put(32'h20, enc_i(T_STORE, 4, 0, 16'h0144));
        put(32'h24, {T_HALT, 26'b0});
        put(32'h140, 32'd4);
        put(32'h150, 32'd3);
        put(32'h154, 32'd5);
        put(32'h158, 32'hFFFF_FFFE);
        put(32'h15C, 32'd10);
        run_prog(400);
        check(dmem[32'h144 >> 2] == 32'd16, "R7", "loop sum", dmem[32'h144 >> 2], 32'd16);

        // Program 3: signed compares, register 0, unassigned opcode (R8, R9, R11).
        clear_mem();
        put(32'h00, enc_i(T_ADDI, 1, 0, 16'hFFFD));
        put(32'h04, enc_i(T_ADDI, 2, 0, 16'h0002));
        put(32'h08, enc_i(T_BGT, 1, 2, 16'h0002));
        put(32'h0C, enc_i(T_STORE, 1, 0, 16'h0180));
        put(32'h10, enc_i(T_BGT, 2, 1, 16'h0001));
        put(32'h14, enc_i(T_STORE, 2, 0, 16'h0184));
        put(32'h18, enc_i(T_ADDI, 0, 0, 16'd99));
        put(32'h1C, enc_i(T_STORE, 0, 0, 16'h0188));
        put(32'h20, {6'h2A, 26'h155_5555});
        put(32'h24, enc_r(T_SUB, 3, 2, 1));
        put(32'h28, enc_i(T_SUBI, 4, 3, 16'hFFF9));
        put(32'h2C, enc_i(T_STORE, 3, 0, 16'h018C));
        put(32'h30, enc_i(T_STORE, 4, 0, 16'h0190));
        put(32'h34, enc_i(T_BGTZ, 0, 0, 16'h0001));
        put(32'h38, enc_i(T_BGTZ, 1, 0, 16'h0001));
        put(32'h3C, {T_HALT, 26'b0});
        put(32'h184, 32'h0000_DEAD);
        put(32'h188, 32'h0000_0055);
        run_prog(400);
        check(dmem[32'h180 >> 2] == 32'hFFFF_FFFD, "R8", "not-taken path store", dmem[32'h180 >> 2], 32'hFFFF_FFFD);
        check(dmem[32'h184 >> 2] == 32'h0000_DEAD, "R8", "taken branch skipped store", dmem[32'h184 >> 2], 32'h0000_DEAD);
        check(dmem[32'h188 >> 2] == 32'h0, "R9", "register 0 stays zero", dmem[32'h188 >> 2], 32'h0);
        check(dmem[32'h18C >> 2] == 32'd5, "R6", "register subtract", dmem[32'h18C >> 2], 32'd5);
        check(dmem[32'h190 >> 2] == 32'd12, "R6", "immediate subtract", dmem[32'h190 >> 2], 32'd12);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule